// File: doc/BRIEF.md
# Video Region Color Averager

The block sits behind a video receiver and watches a stream of 24-bit pixels, one per pixel clock. From the two sync inputs it works out each pixel's column and row. It keeps a running red, green and blue sum for each rectangular screen tile. At the end of every frame it publishes the per-tile mean colour, which an ambient light string can then display.

The tiles form a grid of GRID_X by GRID_Y cells. The first cell starts at (ORIGIN_X, ORIGIN_Y), and each cell is 2^LOG_W pixels wide and 2^LOG_H lines tall. Because every tile covers a power-of-two number of pixels, the mean is simply the top eight bits of the tile's sum, and no divider is needed.

The storage has two copies. One copy collects the frame that is arriving, while the other holds the last finished frame for the read port. The copies trade roles at each frame boundary.

The control is a two-state machine. HUNT is the state after reset, where the pixel position is unknown and the stream is ignored. ACCUM is the state where pixels are summed. The transition HUNT→ACCUM is taken on the first vsync. ACCUM→ACCUM is taken on every later vsync and performs the buffer swap.

Top module: `rgn_color_avg`

## Requirements
- R1: The column counter starts at 0 in the cycle after an hsync or vsync cycle and rises by one each pixel cycle. The row counter rises by one after each hsync cycle and is 0 after a vsync cycle.
- R2: Tile i lies at grid column i mod GRID_X and row i div GRID_X. It covers columns ORIGIN_X+col·2^LOG_W up to, but not including, ORIGIN_X+(col+1)·2^LOG_W, and the same pattern applies to rows using ORIGIN_Y and LOG_H. A pixel adds to the tile that contains it. A pixel outside every tile changes no average.
- R3: A published average equals floor(sum / 2^(LOG_W+LOG_H)). A tile whose pixels are all 255 reads 255, so the sum never overflows.
- R4: A cycle with hsync or vsync high carries no pixel. When both are high, vsync wins: both counters go to 0 and the frame closes.
- R5: After reset the block is in HUNT. Pixels are ignored until the first vsync, which enters ACCUM without raising frame_done.
- R6: Each vsync in ACCUM swaps the copies, so the next frame starts from empty sums. frame_done is high for exactly the one cycle after that vsync and low at all other times.
- R7: rd_data returns, one cycle after rd_region/rd_color are presented, the average of that tile from the finished copy. The colour codes are 0 for red (pix_rgb[23:16]), 1 for green ([15:8]) and 2 for blue ([7:0]). Colour code 3, or a tile index at or above GRID_X·GRID_Y, returns 0.
- R8: Reads made while a frame is being summed return the previous finished frame. A read presented in the vsync cycle still returns the older frame, and a read presented in the next cycle returns the new one.
- R9: A synchronous active-high reset clears both copies, the select bit, frame_done and rd_data, and returns the block to HUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_rgb | input | 24 | Pixel colour: red [23:16], green [15:8], blue [7:0] |
| hsync | input | 1 | One-cycle line-end marker |
| vsync | input | 1 | One-cycle frame-end marker |
| rd_region | input | $clog2(GRID_X*GRID_Y) | Tile index to read |
| rd_color | input | 2 | Colour code to read |
| rd_data | output | 8 | Registered average |
| frame_done | output | 1 | One-cycle strobe after a buffer swap |

## Verification
A pixel is counted at the clock edge that ends its cycle. The sync cycle that closes a frame makes frame_done high in the following cycle, and the swapped copy is visible from that same cycle. A read address presented in one cycle yields rd_data in the next. The bench drives every input half a period before the sampling edge and compares one half period after it. It queues each read's expected value when the address is driven and pops it one cycle later. The expected value is taken from the bench's own frame model before or after the swap, according to the cycle in which the read was presented.

// File: rtl/rgn_avg_pkg.sv
package rgn_avg_pkg;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_ACCUM = 1'b1
    } frame_state_e;

    typedef enum logic [1:0] {
        COL_RED  = 2'd0,
        COL_GRN  = 2'd1,
        COL_BLU  = 2'd2,
        COL_NONE = 2'd3
    } color_sel_e;

    localparam int NUM_COLORS = 3;
    localparam int CHAN_W     = 8;

endpackage

// File: rtl/rgn_pos_counter.sv
module rgn_pos_counter #(
    parameter int XW = 12,
    parameter int YW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hsync,
    input  logic          vsync,
    output logic [XW-1:0] pos_x,
    output logic [YW-1:0] pos_y
);

    localparam logic [XW-1:0] X_TOP = '1;
    localparam logic [YW-1:0] Y_TOP = '1;

    // Counters saturate so an over-long line or frame never wraps into a tile.
    always_ff @(posedge clk) begin
        if (rst || vsync) begin
            pos_x <= '0;
            pos_y <= '0;
        end else if (hsync) begin
            pos_x <= '0;
            pos_y <= (pos_y == Y_TOP) ? pos_y : pos_y + 1'b1;
        end else begin
            pos_x <= (pos_x == X_TOP) ? pos_x : pos_x + 1'b1;
        end
    end

endmodule

// File: rtl/rgn_match.sv
module rgn_match #(
    parameter int GRID_X   = 5,
    parameter int GRID_Y   = 5,
    parameter int ORIGIN_X = 64,
    parameter int ORIGIN_Y = 32,
    parameter int LOG_W    = 7,
    parameter int LOG_H    = 6,
    parameter int XW       = 12,
    parameter int YW       = 11,
    localparam int NREG    = GRID_X * GRID_Y
) (
    input  logic [XW-1:0]   pos_x,
    input  logic [YW-1:0]   pos_y,
    input  logic            pix_valid,
    output logic [NREG-1:0] hit
);

    localparam int TILE_W = 1 << LOG_W;
    localparam int TILE_H = 1 << LOG_H;

    for (genvar i = 0; i < NREG; i++) begin : g_tile
        localparam int COL  = i % GRID_X;
        localparam int ROW  = i / GRID_X;
        localparam int X_LO = ORIGIN_X + COL * TILE_W;
        localparam int X_HI = X_LO + TILE_W;
        localparam int Y_LO = ORIGIN_Y + ROW * TILE_H;
        localparam int Y_HI = Y_LO + TILE_H;

        logic in_x;
        logic in_y;
        assign in_x   = (int'(pos_x) >= X_LO) && (int'(pos_x) < X_HI);
        assign in_y   = (int'(pos_y) >= Y_LO) && (int'(pos_y) < Y_HI);
        assign hit[i] = pix_valid && in_x && in_y;
    end

endmodule

// File: rtl/rgn_accum_bank.sv
module rgn_accum_bank
    import rgn_avg_pkg::*;
#(
    parameter int NREG = 25,
    parameter int AW   = 21,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              sel,
    input  logic                              swap,
    input  logic [NREG-1:0]                   hit,
    input  logic [NUM_COLORS-1:0][CHAN_W-1:0] pixv,
    input  logic [IW-1:0]                     rd_idx,
    input  logic [1:0]                        rd_col,
    output logic [CHAN_W-1:0]                 avg
);

    // acc[sel] collects the current frame; acc[~sel] holds the finished one.
    logic [AW-1:0] acc [2][NREG][NUM_COLORS];
    logic          rd_bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int r = 0; r < NREG; r++)
                    for (int c = 0; c < NUM_COLORS; c++)
                        acc[b][r][c] <= '0;
        end else begin
            for (int b = 0; b < 2; b++)
                for (int r = 0; r < NREG; r++)
                    for (int c = 0; c < NUM_COLORS; c++)
                        if (swap && (1'(b) != sel))
                            acc[b][r][c] <= '0;
                        else if ((1'(b) == sel) && hit[r])
                            acc[b][r][c] <= acc[b][r][c] + AW'(pixv[c]);
        end
    end

    assign rd_bank = ~sel;

    always_comb begin
        avg = '0;
        for (int r = 0; r < NREG; r++)
            for (int c = 0; c < NUM_COLORS; c++)
                if ((rd_idx == IW'(r)) && (rd_col == 2'(c)))
                    avg = acc[rd_bank][r][c][AW-1 -: CHAN_W];
    end

endmodule

// File: rtl/rgn_color_avg.sv
module rgn_color_avg
    import rgn_avg_pkg::*;
#(
    parameter int GRID_X   = 5,
    parameter int GRID_Y   = 5,
    parameter int ORIGIN_X = 64,
    parameter int ORIGIN_Y = 32,
    parameter int LOG_W    = 7,
    parameter int LOG_H    = 6,
    parameter int XW       = 12,
    parameter int YW       = 11,
    localparam int NREG    = GRID_X * GRID_Y,
    localparam int IW      = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int AW      = CHAN_W + LOG_W + LOG_H
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [23:0]   pix_rgb,
    input  logic          hsync,
    input  logic          vsync,
    input  logic [IW-1:0] rd_region,
    input  logic [1:0]    rd_color,
    output logic [7:0]    rd_data,
    output logic          frame_done
);

    frame_state_e                     state_q, state_d;
    logic                             accum_on;
    logic                             swap;
    logic                             pix_valid;
    logic                             sel_q;
    logic [XW-1:0]                    pos_x;
    logic [YW-1:0]                    pos_y;
    logic [NREG-1:0]                  hit;
    logic [NUM_COLORS-1:0][CHAN_W-1:0] pixv;
    logic [CHAN_W-1:0]                avg;

    assign pixv[COL_RED] = pix_rgb[23:16];
    assign pixv[COL_GRN] = pix_rgb[15:8];
    assign pixv[COL_BLU] = pix_rgb[7:0];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    // Transitions: HUNT->ACCUM on first vsync, ACCUM->ACCUM (with swap) on each vsync
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (vsync) state_d = ST_ACCUM;
            ST_ACCUM: state_d = ST_ACCUM;
        endcase
    end

    // State-decoded controls
    always_comb begin
        accum_on  = (state_q == ST_ACCUM);
        swap      = accum_on && vsync;
        pix_valid = accum_on && !vsync && !hsync;
    end

    rgn_pos_counter #(.XW(XW), .YW(YW)) u_pos (
        .clk   (clk),
        .rst   (rst),
        .hsync (hsync),
        .vsync (vsync),
        .pos_x (pos_x),
        .pos_y (pos_y)
    );

    rgn_match #(
        .GRID_X(GRID_X), .GRID_Y(GRID_Y), .ORIGIN_X(ORIGIN_X), .ORIGIN_Y(ORIGIN_Y),
        .LOG_W(LOG_W), .LOG_H(LOG_H), .XW(XW), .YW(YW)
    ) u_match (
        .pos_x     (pos_x),
        .pos_y     (pos_y),
        .pix_valid (pix_valid),
        .hit       (hit)
    );

    rgn_accum_bank #(.NREG(NREG), .AW(AW)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel_q),
        .swap   (swap),
        .hit    (hit),
        .pixv   (pixv),
        .rd_idx (rd_region),
        .rd_col (rd_color),
        .avg    (avg)
    );

    // Registered outputs and buffer select
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= 1'b0;
            frame_done <= 1'b0;
            rd_data    <= '0;
        end else begin
            sel_q      <= sel_q ^ swap;
            frame_done <= swap;
            rd_data    <= avg;
        end
    end

endmodule

// File: rtl/rgn_color_avg_chk.sv
module rgn_color_avg_chk #(
    parameter int NREG = 25,
    parameter int IW   = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            vsync,
    input logic [IW-1:0]   rd_region,
    input logic [1:0]      rd_color,
    input logic [7:0]      rd_data,
    input logic            frame_done,
    input logic            sel,
    input logic [NREG-1:0] hit,
    input logic            accum_on
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    assert_done_after_vsync_R6: assert property (@(posedge clk) disable iff (rst)
        (vsync && accum_on) |=> frame_done);

    assert_done_has_cause_R6: assert property (@(posedge clk) disable iff (rst || rst_q)
        frame_done |-> $past(vsync));

    assert_sel_flips_R6: assert property (@(posedge clk) disable iff (rst || rst_q)
        frame_done |-> (sel != $past(sel)));

    assert_sel_holds_R6: assert property (@(posedge clk) disable iff (rst || rst_q)
        !frame_done |-> $stable(sel));

    assert_hunt_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !accum_on |=> !frame_done);

    assert_single_tile_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    assert_null_read_R7: assert property (@(posedge clk) disable iff (rst)
        ((rd_color == 2'd3) || (int'(rd_region) >= NREG)) |=> (rd_data == 8'd0));

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (rd_data == 8'd0 && !frame_done && !sel && !accum_on));

endmodule

bind rgn_color_avg rgn_color_avg_chk #(.NREG(NREG), .IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .vsync      (vsync),
    .rd_region  (rd_region),
    .rd_color   (rd_color),
    .rd_data    (rd_data),
    .frame_done (frame_done),
    .sel        (sel_q),
    .hit        (hit),
    .accum_on   (accum_on)
);

// File: tb/test_rgn_color_avg.sv
`timescale 1ns/1ps
module test_rgn_color_avg;

    localparam int GX = 5, GY = 5, OX = 2, OY = 1, LW = 2, LH = 1, XW = 8, YW = 8;
    localparam int NREG  = GX * GY;
    localparam int IW    = $clog2(NREG);
    localparam int LINE  = 24;
    localparam int LINES = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [23:0]   pix_rgb;
    logic          hsync, vsync;
    logic [IW-1:0] rd_region;
    logic [1:0]    rd_color;
    logic [7:0]    rd_data;
    logic          frame_done;

    rgn_color_avg #(
        .GRID_X(GX), .GRID_Y(GY), .ORIGIN_X(OX), .ORIGIN_Y(OY),
        .LOG_W(LW), .LOG_H(LH), .XW(XW), .YW(YW)
    ) i_rgn_color_avg (
        .clk(clk), .rst(rst), .pix_rgb(pix_rgb), .hsync(hsync), .vsync(vsync),
        .rd_region(rd_region), .rd_color(rd_color), .rd_data(rd_data),
        .frame_done(frame_done)
    );

    always #2.5 clk = ~clk;

    int    n_checks = 0, n_fail = 0;
    bit    finished = 0;
    int    model_acc [NREG][3];
    int    exp_done  [NREG][3];
    int    bx = 0, by = 0, rk = 0;
    bit    accum = 0;
    int    exp_q [$];
    string tag_q [$];
    logic  rd_issue = 1'b0, issued_q = 1'b0;

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int region_of(int x, int y);
        int col, row;
        if (x < OX || y < OY) return -1;
        col = (x - OX) >> LW;
        row = (y - OY) >> LH;
        if (col >= GX || row >= GY) return -1;
        return row * GX + col;
    endfunction

    function automatic int px(int pat, int x, int y, int c);
        case (pat)
            0:       return (x * 7 + y * 13 + c * 50) & 255;
            1:       return 255;
            2:       return (region_of(x, y) >= 0) ? 0 : 255;
            default: return ((x * 29) ^ (y * 17 + c * 91)) & 255;
        endcase
    endfunction

    // Scoreboard monitor: a read presented in one cycle is due one cycle later
    always @(posedge clk) issued_q <= rd_issue;
    always @(negedge clk) begin
        if (issued_q && exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(rd_data), e);
        end
    end

    // Driver: present a read and push its expectation (R7 for null codes)
    task automatic issue_read(string tag);
        int r, c, e;
        r = rk % 32;
        c = (rk / 32) % 4;
        rd_region = IW'(r);
        rd_color  = 2'(c);
        if (r < NREG && c < 3) begin
            e = exp_done[r][c];
            tag_q.push_back(tag);
        end else begin
            e = 0;
            tag_q.push_back("R7");
        end
        exp_q.push_back(e);
        rd_issue = 1'b1;
        rk++;
    endtask

    task automatic pix_cycle(int pat, string tag);
        int reg_i;
        pix_rgb = {8'(px(pat, bx, by, 0)), 8'(px(pat, bx, by, 1)), 8'(px(pat, bx, by, 2))};
        hsync = 1'b0;
        vsync = 1'b0;
        reg_i = region_of(bx, by);
        if (accum && reg_i >= 0)
            for (int c = 0; c < 3; c++) model_acc[reg_i][c] += px(pat, bx, by, c);
        issue_read(tag);
        bx++;
        @(negedge clk);
        check("R6", int'(frame_done), 0);
    endtask

    task automatic hs_cycle(string tag);
        hsync = 1'b1;
        vsync = 1'b0;
        pix_rgb = 24'hFFFFFF;
        issue_read(tag);
        bx = 0;
        by++;
        @(negedge clk);
        check("R6", int'(frame_done), 0);
    endtask

    task automatic vs_cycle(bit with_h, string tag);
        bit was;
        hsync = with_h;
        vsync = 1'b1;
        pix_rgb = 24'hFFFFFF;
        issue_read(tag);   // sampled at the swap edge: older frame expected (R8)
        was = accum;
        if (accum)
            for (int r = 0; r < NREG; r++)
                for (int c = 0; c < 3; c++) begin
                    exp_done[r][c]  = model_acc[r][c] >> (LW + LH);
                    model_acc[r][c] = 0;
                end
        accum = 1;
        bx = 0;
        by = 0;
        @(negedge clk);
        if (was) check("R6", int'(frame_done), 1);
        else     check("R5", int'(frame_done), 0);
    endtask

    task automatic send_lines(int pat, int nlines, int tail, string tag);
        for (int l = 0; l < nlines; l++) begin
            for (int x = 0; x < LINE; x++) pix_cycle(pat, tag);
            hs_cycle(tag);
        end
        for (int x = 0; x < tail; x++) pix_cycle(pat, tag);
    endtask

    task automatic quiesce();
        rd_issue = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        hsync = 1'b0;
        vsync = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", int'(rd_data), 0);
        check("R9", int'(frame_done), 0);
        for (int r = 0; r < NREG; r++)
            for (int c = 0; c < 3; c++) begin
                model_acc[r][c] = 0;
                exp_done[r][c]  = 0;
            end
        accum = 0;
        bx = 0;
        by = 0;
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pix_rgb = '0;
        hsync = 1'b0;
        vsync = 1'b0;
        rd_region = '0;
        rd_color = '0;
        for (int r = 0; r < NREG; r++)
            for (int c = 0; c < 3; c++) begin
                model_acc[r][c] = 0;
                exp_done[r][c]  = 0;
            end
        repeat (3) @(negedge clk);
        check("R9", int'(rd_data), 0);
        check("R9", int'(frame_done), 0);
        rst = 1'b0;

        send_lines(0, 5, 7, "R5");      // stream before first vsync: ignored
        vs_cycle(1'b0, "R5");           // enters ACCUM, no strobe
        send_lines(0, LINES, 0, "R8");  // frame A; reads still see nothing
        vs_cycle(1'b0, "R8");
        send_lines(1, LINES, 0, "R1");  // reads check A tile mapping
        vs_cycle(1'b0, "R8");
        send_lines(2, LINES, 0, "R3");  // reads check all-255 frame
        vs_cycle(1'b1, "R4");           // hsync with vsync: vsync wins
        send_lines(3, 6, 9, "R2");      // reads check outside-only frame
        vs_cycle(1'b0, "R8");           // truncated frame closes mid-line
        send_lines(0, LINES, 0, "R8");
        vs_cycle(1'b0, "R7");
        send_lines(3, 2, 0, "R7");

        quiesce();
        do_reset();
        send_lines(1, LINES, 0, "R9");  // cleared buffers, HUNT again
        vs_cycle(1'b0, "R5");
        send_lines(3, LINES, 0, "R9");
        vs_cycle(1'b0, "R6");
        send_lines(0, 3, 0, "R8");
        quiesce();

        finished = 1;
        summary();
        $finish;
    end

endmodule